// File: doc/BRIEF.md
# CAN FD Dual-Rate Bit Timing Generator

This block produces the time-quantum clock and the segment timing of one CAN FD bit. It holds two timing sets. The nominal set runs the arbitration phase. The data set runs the fast phase. A phase-select input picks the set that the next bit will use. Each bit is cut into three segments: a one-quantum synchronization segment, a first timing segment, and a second timing segment. The sample point sits at the end of the first timing segment.

Every programmed field is written as the count minus one. A divider field of 0 therefore gives one clock per quantum. A first-segment field of 126 gives 127 quanta. The nominal set has wider fields than the data set. A falling edge (recessive to dominant) on the receive line can resynchronize the bit once per bit. The jump width limits how far the bit can move. A hard-sync pulse restarts the bit and the quantum divider at once. The surrounding protocol engine reads the strobes to sample bits and to frame them.

Top module: `can_fd_bittime`

## Requirements
- R1: While reset is held, `seg` is 0 (synchronization), `sample_pt`, `bit_end` and `data_phase` are 0.
- R2: After a restart, `tq_tick` is high on one clock in every (div+1) clocks, first on clock div (counting from 0), where div is the divider field of the active set.
- R3: A bit is 1 quantum of synchronization (`seg`=0), then seg1+1 quanta of first segment (`seg`=1), then seg2+1 quanta of second segment (`seg`=2). `sample_pt` pulses on the tick that ends the first segment. `bit_end` pulses on the tick that ends the second segment.
- R4: While `data_phase` is 1, the data-set fields (8-bit divider, 5-bit seg1, 4-bit seg2, 4-bit jump) set the bit timing. While it is 0, the nominal fields (8, 8, 7, 7 bits) set it.
- R5: `data_phase` takes the value of `rate_sel` only on a clock where `bit_end` is high. A change of `rate_sel` in the middle of a bit has no effect on the current bit.
- R6: A `hard_sync` pulse restarts the bit in the synchronization segment. The quantum divider restarts from zero on the same clock.
- R7: A falling edge of `rx` first seen while the first segment is at quantum index c (counting from 0) lengthens that segment by min(c+1, J) quanta, where J is the effective jump width.
- R8: A falling edge of `rx` first seen while the second segment is at quantum index c shortens that segment by min(seg2 − c, J) quanta, where seg2 is the field value and seg2 − c is the number of quanta still to come.
- R9: At most one resynchronization happens per bit. An edge seen during the synchronization segment has no effect.
- R10: The effective jump width J is the smallest of jump+1, seg1+1 and seg2+1 of the active set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CAN clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nom_div | input | 8 | Nominal quantum divider, minus one |
| nom_seg1 | input | 8 | Nominal first segment length, minus one |
| nom_seg2 | input | 7 | Nominal second segment length, minus one |
| nom_jump | input | 7 | Nominal jump width, minus one |
| dat_div | input | 8 | Data quantum divider, minus one |
| dat_seg1 | input | 5 | Data first segment length, minus one |
| dat_seg2 | input | 4 | Data second segment length, minus one |
| dat_jump | input | 4 | Data jump width, minus one |
| rate_sel | input | 1 | Requested set for the next bit (1 = data) |
| hard_sync | input | 1 | Restarts the bit and the divider |
| rx | input | 1 | Receive line, already synchronous to clk |
| tq_tick | output | 1 | End of a time quantum |
| sample_pt | output | 1 | Sample-point strobe |
| bit_end | output | 1 | Bit-boundary strobe |
| seg | output | 2 | Current segment: 0 sync, 1 first, 2 second |
| data_phase | output | 1 | Set in use for the current bit (1 = data) |

## Verification
The assertions assume that the timing fields stay still while a bit is running and change only just before a hard sync. They also assume that `rx` is already synchronous to the clock. The bench keeps to both assumptions. It writes each new configuration and then pulses `hard_sync` before it measures anything. It drives `rx` only on falling clock edges and sets it back high between bits. Rate switches are asked for in the middle of a bit, so the bench can check that the switch waits for the boundary.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

    // Segment codes; the protocol engine decodes these values.
    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_TS1  = 2'd1,
        SEG_TS2  = 2'd2
    } seg_e;

endpackage

// File: rtl/can_bt_cfgsel.sv
// Picks the active timing set, decodes minus-one fields and clamps the jump width.
module can_bt_cfgsel #(
    parameter int NDIV_W = 8,
    parameter int NS1_W  = 8,
    parameter int NS2_W  = 7,
    parameter int NJ_W   = 7,
    parameter int DDIV_W = 8,
    parameter int DS1_W  = 5,
    parameter int DS2_W  = 4,
    parameter int DJ_W   = 4,
    parameter int DIV_W  = 8,
    parameter int LEN_W  = 9
) (
    input  logic [NDIV_W-1:0] nom_div,
    input  logic [NS1_W-1:0]  nom_seg1,
    input  logic [NS2_W-1:0]  nom_seg2,
    input  logic [NJ_W-1:0]   nom_jump,
    input  logic [DDIV_W-1:0] dat_div,
    input  logic [DS1_W-1:0]  dat_seg1,
    input  logic [DS2_W-1:0]  dat_seg2,
    input  logic [DJ_W-1:0]   dat_jump,
    input  logic              use_data,
    output logic [DIV_W-1:0]  div_act,
    output logic [LEN_W-1:0]  s1_len,
    output logic [LEN_W-1:0]  s2_len,
    output logic [LEN_W-1:0]  jump_len
);

    logic [LEN_W-1:0] jump_raw;

    always_comb begin
        if (use_data) begin
            div_act  = DIV_W'(dat_div);
            s1_len   = LEN_W'(dat_seg1) + LEN_W'(1);
            s2_len   = LEN_W'(dat_seg2) + LEN_W'(1);
            jump_raw = LEN_W'(dat_jump) + LEN_W'(1);
        end else begin
            div_act  = DIV_W'(nom_div);
            s1_len   = LEN_W'(nom_seg1) + LEN_W'(1);
            s2_len   = LEN_W'(nom_seg2) + LEN_W'(1);
            jump_raw = LEN_W'(nom_jump) + LEN_W'(1);
        end
        jump_len = jump_raw;
        if (s1_len < jump_len) jump_len = s1_len;
        if (s2_len < jump_len) jump_len = s2_len;
        // R10 guard, immediate form
        a_jump_clamp_r10: assert (jump_len <= s1_len && jump_len <= s2_len && jump_len != '0);
    end

endmodule

// File: rtl/can_bt_prescaler.sv
// Divides the CAN clock into time quanta.
module can_bt_prescaler #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_act,
    output logic             tick
);

    logic [DIV_W-1:0] pc_d, pc_q;

    assign tick = (pc_q >= div_act);

    always_comb begin
        if (restart)   pc_d = '0;
        else if (tick) pc_d = '0;
        else           pc_d = pc_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    p_restart_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (pc_q == '0));

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> (pc_q == $past(pc_q) + DIV_W'(1)));

    p_wrap_after_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart) |=> (pc_q == '0));

endmodule

// File: rtl/can_bt_segctl.sv
// Segment sequencer with edge resynchronization and rate-set latch.
module can_bt_segctl
    import can_bt_pkg::*;
#(
    parameter int LEN_W = 9,
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             hard_sync,
    input  logic             rx,
    input  logic             rate_sel,
    input  logic [LEN_W-1:0] s1_len,
    input  logic [LEN_W-1:0] s2_len,
    input  logic [LEN_W-1:0] jump_len,
    output logic             sample_pt,
    output logic             bit_end,
    output logic [1:0]       seg,
    output logic             data_phase
);

    typedef struct packed {
        seg_e             seg;
        logic [CNT_W-1:0] cnt;
        logic [LEN_W-1:0] ext;
        logic [LEN_W-1:0] shr;
        logic             used;
        logic             dphase;
        logic             rx_s1;
        logic             rx_s2;
    } st_t;

    st_t st_d, st_q;

    logic             edge_seen, rs_ok, s1_last, s2_last, samp, bend;
    logic [CNT_W-1:0] e_val, rem, s1_stop, s2_stop;

    always_comb begin
        st_d       = st_q;
        st_d.rx_s1 = rx;
        st_d.rx_s2 = st_q.rx_s1;

        edge_seen = st_q.rx_s2 && !st_q.rx_s1;
        rs_ok     = edge_seen && !st_q.used && (st_q.seg != SEG_SYNC);
        e_val     = st_q.cnt + CNT_W'(1);
        rem       = CNT_W'(s2_len) - CNT_W'(1) - st_q.cnt;

        if (rs_ok) begin
            st_d.used = 1'b1;
            if (st_q.seg == SEG_TS1)
                st_d.ext = (e_val > CNT_W'(jump_len)) ? jump_len : LEN_W'(e_val);
            else
                st_d.shr = (rem > CNT_W'(jump_len)) ? jump_len : LEN_W'(rem);
        end

        s1_stop = CNT_W'(s1_len) - CNT_W'(1) + CNT_W'(st_d.ext);
        s2_stop = CNT_W'(s2_len) - CNT_W'(1);
        s1_last = (st_q.cnt >= s1_stop);
        s2_last = ((st_q.cnt + CNT_W'(st_d.shr)) >= s2_stop);
        samp    = tick && (st_q.seg == SEG_TS1) && s1_last;
        bend    = tick && (st_q.seg == SEG_TS2) && s2_last;

        if (tick) begin
            unique case (st_q.seg)
                SEG_SYNC: begin
                    st_d.seg = SEG_TS1;
                    st_d.cnt = '0;
                end
                SEG_TS1: begin
                    if (s1_last) begin
                        st_d.seg = SEG_TS2;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end
                default: begin
                    if (s2_last) begin
                        st_d.seg    = SEG_SYNC;
                        st_d.cnt    = '0;
                        st_d.ext    = '0;
                        st_d.shr    = '0;
                        st_d.used   = 1'b0;
                        st_d.dphase = rate_sel;
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end
            endcase
        end

        if (hard_sync) begin
            st_d.seg  = SEG_SYNC;
            st_d.cnt  = '0;
            st_d.ext  = '0;
            st_d.shr  = '0;
            st_d.used = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{seg: SEG_SYNC, cnt: '0, ext: '0, shr: '0, used: 1'b0,
                      dphase: 1'b0, rx_s1: 1'b1, rx_s2: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign sample_pt  = samp;
    assign bit_end    = bend;
    assign seg        = st_q.seg;
    assign data_phase = st_q.dphase;

    p_strobe_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_pt || bit_end) |-> tick);

    p_sync_one_tq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.seg == SEG_SYNC && tick && !hard_sync) |=> (st_q.seg == SEG_TS1));

    p_phase_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_end |=> $stable(st_q.dphase));

    p_hard_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hard_sync |=> (st_q.seg == SEG_SYNC && st_q.cnt == '0));

    p_one_resync_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.used && !bit_end && !hard_sync) |=> st_q.used);

    p_ext_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ext <= jump_len) && (st_q.shr <= jump_len));

endmodule

// File: rtl/can_fd_bittime.sv
module can_fd_bittime #(
    parameter int NDIV_W = 8,
    parameter int NS1_W  = 8,
    parameter int NS2_W  = 7,
    parameter int NJ_W   = 7,
    parameter int DDIV_W = 8,
    parameter int DS1_W  = 5,
    parameter int DS2_W  = 4,
    parameter int DJ_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NDIV_W-1:0] nom_div,
    input  logic [NS1_W-1:0]  nom_seg1,
    input  logic [NS2_W-1:0]  nom_seg2,
    input  logic [NJ_W-1:0]   nom_jump,
    input  logic [DDIV_W-1:0] dat_div,
    input  logic [DS1_W-1:0]  dat_seg1,
    input  logic [DS2_W-1:0]  dat_seg2,
    input  logic [DJ_W-1:0]   dat_jump,
    input  logic              rate_sel,
    input  logic              hard_sync,
    input  logic              rx,
    output logic              tq_tick,
    output logic              sample_pt,
    output logic              bit_end,
    output logic [1:0]        seg,
    output logic              data_phase
);

    localparam int DIV_W = (NDIV_W > DDIV_W) ? NDIV_W : DDIV_W;
    localparam int W_A   = (NS1_W > NS2_W) ? NS1_W : NS2_W;
    localparam int W_B   = (W_A > NJ_W) ? W_A : NJ_W;
    localparam int W_C   = (DS1_W > DS2_W) ? DS1_W : DS2_W;
    localparam int W_D   = (W_C > DJ_W) ? W_C : DJ_W;
    localparam int FLD_W = (W_B > W_D) ? W_B : W_D;
    localparam int LEN_W = FLD_W + 1;
    localparam int CNT_W = LEN_W + 1;

    logic [DIV_W-1:0] div_act;
    logic [LEN_W-1:0] s1_len, s2_len, jump_len;

    can_bt_cfgsel #(
        .NDIV_W(NDIV_W), .NS1_W(NS1_W), .NS2_W(NS2_W), .NJ_W(NJ_W),
        .DDIV_W(DDIV_W), .DS1_W(DS1_W), .DS2_W(DS2_W), .DJ_W(DJ_W),
        .DIV_W(DIV_W), .LEN_W(LEN_W)
    ) u_cfgsel (
        .nom_div (nom_div),
        .nom_seg1(nom_seg1),
        .nom_seg2(nom_seg2),
        .nom_jump(nom_jump),
        .dat_div (dat_div),
        .dat_seg1(dat_seg1),
        .dat_seg2(dat_seg2),
        .dat_jump(dat_jump),
        .use_data(data_phase),
        .div_act (div_act),
        .s1_len  (s1_len),
        .s2_len  (s2_len),
        .jump_len(jump_len)
    );

    can_bt_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(hard_sync),
        .div_act(div_act),
        .tick   (tq_tick)
    );

    can_bt_segctl #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_segctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tq_tick),
        .hard_sync (hard_sync),
        .rx        (rx),
        .rate_sel  (rate_sel),
        .s1_len    (s1_len),
        .s2_len    (s2_len),
        .jump_len  (jump_len),
        .sample_pt (sample_pt),
        .bit_end   (bit_end),
        .seg       (seg),
        .data_phase(data_phase)
    );

endmodule

// File: tb/tb_can_fd_bittime.sv
module tb_can_fd_bittime;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] nom_div = '0, nom_seg1 = '0, dat_div = '0;
    logic [6:0] nom_seg2 = '0, nom_jump = '0;
    logic [4:0] dat_seg1 = '0;
    logic [3:0] dat_seg2 = '0, dat_jump = '0;
    logic       rate_sel = 1'b0, hard_sync = 1'b0, rx = 1'b1;
    logic       tq_tick, sample_pt, bit_end, data_phase;
    logic [1:0] seg;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    can_fd_bittime dut (
        .clk(clk), .rst_n(rst_n),
        .nom_div(nom_div), .nom_seg1(nom_seg1), .nom_seg2(nom_seg2), .nom_jump(nom_jump),
        .dat_div(dat_div), .dat_seg1(dat_seg1), .dat_seg2(dat_seg2), .dat_jump(dat_jump),
        .rate_sel(rate_sel), .hard_sync(hard_sync), .rx(rx),
        .tq_tick(tq_tick), .sample_pt(sample_pt), .bit_end(bit_end),
        .seg(seg), .data_phase(data_phase)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_hs(input bit rx_low);
        @(negedge clk);
        hard_sync = 1'b1;
        if (rx_low) rx = 1'b0;
        @(negedge clk);
        hard_sync = 1'b0;
    endtask

    // Sample index i = clocks since the restart edge. Drives rx after sampling.
    task automatic measure(input int bq, input int f1, input int r1, input int f2,
                           output int ts, output int te, output int bad);
        ts = -1; te = -1; bad = 0;
        for (int i = 0; i < 5000; i++) begin
            if (tq_tick !== (((i + 1) % (bq + 1)) == 0)) bad++;
            if (i == 0 && seg != 2'd0) bad++;
            if (sample_pt && seg != 2'd1) bad++;
            if (bit_end && seg != 2'd2) bad++;
            if (sample_pt && ts < 0) ts = i;
            if (bit_end) begin
                te = i;
                break;
            end
            if (i == f1) rx = 1'b0;
            if (i == r1) rx = 1'b1;
            if (i == f2) rx = 1'b0;
            @(negedge clk);
        end
        rx = 1'b1;
    endtask

    task automatic nom_bit(input int b, input int s1, input int s2, input string req);
        int ts, te, bad;
        nom_div = 8'(b); nom_seg1 = 8'(s1); nom_seg2 = 7'(s2);
        do_hs(1'b0);
        measure(b, -1, -1, -1, ts, te, bad);
        chk(ts == (2 + s1) * (b + 1) - 1, {req, " sample"}, ts, (2 + s1) * (b + 1) - 1);
        chk(te == (3 + s1 + s2) * (b + 1) - 1, {req, " end"}, te, (3 + s1 + s2) * (b + 1) - 1);
        chk(bad == 0, "R2 tick/seg shape", bad, 0);
    endtask

    task automatic resync_case(input int s1, input int s2, input int jw, input bit rx_hs,
                               input int f1, input int r1, input int f2,
                               input int ets, input int ete, input string req);
        int ts, te, bad;
        nom_div = 8'd0; nom_seg1 = 8'(s1); nom_seg2 = 7'(s2); nom_jump = 7'(jw);
        do_hs(rx_hs);
        measure(0, f1, r1, f2, ts, te, bad);
        chk(ts == ets, {req, " sample"}, ts, ets);
        chk(te == ete, {req, " end"}, te, ete);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        int ts, te, bad;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(seg == 2'd0, "R1 seg", int'(seg), 0);
        chk(!sample_pt && !bit_end, "R1 strobes", int'({sample_pt, bit_end}), 0);
        chk(data_phase == 1'b0, "R1 data_phase", int'(data_phase), 0);
        rst_n = 1'b1;
        nom_jump = 7'd0;

        // R2/R3 nominal sweep
        for (int b = 0; b < 3; b++)
            for (int s1 = 1; s1 < 4; s1++)
                for (int s2 = 0; s2 < 3; s2++)
                    nom_bit(b, s1, s2, "R3");
        // R3 widest nominal segments
        nom_bit(0, 255, 127, "R3 max");

        // R4/R5 data phase and rate switch at boundary
        for (int b = 0; b < 2; b++)
            for (int d1 = 0; d1 < 3; d1++)
                for (int d2 = 0; d2 < 2; d2++) begin
                    nom_div = 8'd0; nom_seg1 = 8'd2; nom_seg2 = 7'd1;
                    dat_div = 8'(b); dat_seg1 = 5'(d1); dat_seg2 = 4'(d2);
                    do_hs(1'b0);
                    rate_sel = 1'b1;
                    chk(data_phase == 1'b0, "R5 no mid-bit switch", int'(data_phase), 0);
                    measure(0, -1, -1, -1, ts, te, bad);
                    chk(te == 5, "R5 current bit stays nominal", te, 5);
                    @(negedge clk);
                    chk(data_phase == 1'b1, "R5 switch at boundary", int'(data_phase), 1);
                    rate_sel = 1'b0;
                    measure(b, -1, -1, -1, ts, te, bad);
                    chk(ts == (2 + d1) * (b + 1) - 1, "R4 data sample", ts, (2 + d1) * (b + 1) - 1);
                    chk(te == (3 + d1 + d2) * (b + 1) - 1, "R4 data end", te, (3 + d1 + d2) * (b + 1) - 1);
                    chk(bad == 0, "R2 data tick shape", bad, 0);
                    @(negedge clk);
                    chk(data_phase == 1'b0, "R5 back to nominal", int'(data_phase), 0);
                    measure(0, -1, -1, -1, ts, te, bad);
                    chk(ts == 3 && te == 5, "R5 nominal after data", te, 5);
                end

        // R4 widest data segments
        dat_div = 8'd0; dat_seg1 = 5'd31; dat_seg2 = 4'd15;
        nom_div = 8'd0; nom_seg1 = 8'd1; nom_seg2 = 7'd0;
        do_hs(1'b0);
        rate_sel = 1'b1;
        measure(0, -1, -1, -1, ts, te, bad);
        @(negedge clk);
        rate_sel = 1'b0;
        measure(0, -1, -1, -1, ts, te, bad);
        chk(ts == 32, "R4 max data sample", ts, 32);
        chk(te == 48, "R4 max data end", te, 48);
        @(negedge clk);
        measure(0, -1, -1, -1, ts, te, bad);

        // R6 hard sync in the middle of a bit
        nom_div = 8'd2; nom_seg1 = 8'd3; nom_seg2 = 7'd2;
        do_hs(1'b0);
        repeat (7) @(negedge clk);
        do_hs(1'b0);
        measure(2, -1, -1, -1, ts, te, bad);
        chk(ts == 14, "R6 restart sample", ts, 14);
        chk(te == 23, "R6 restart end", te, 23);
        chk(bad == 0, "R6 divider restart", bad, 0);

        // R7 lengthen first segment (seg1 len 4, seg2 len 3, jump len 2)
        resync_case(3, 2, 1, 1'b0, 0, -1, -1, 5, 8, "R7 edge c=0");
        resync_case(3, 2, 1, 1'b0, 1, -1, -1, 6, 9, "R7 edge c=1");
        resync_case(3, 2, 1, 1'b0, 2, -1, -1, 6, 9, "R7 jump limited");
        // R9 second edge ignored, edge in sync ignored
        resync_case(3, 2, 1, 1'b0, 0, 1, 3, 5, 8, "R9 one per bit");
        resync_case(3, 2, 1, 1'b1, -1, -1, -1, 4, 7, "R9 sync edge ignored");
        // R8 shorten second segment (seg2 len 4)
        resync_case(3, 3, 0, 1'b0, 4, -1, -1, 4, 7, "R8 shorten by jump");
        resync_case(3, 3, 1, 1'b0, 5, -1, -1, 4, 6, "R8 shorten to now");
        // R10 clamp: jump field 7 but seg2 len 2
        resync_case(3, 1, 7, 1'b0, 3, -1, -1, 6, 8, "R10 clamp");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule